// File: doc/BRIEF.md
# Dual-Lane Receiver Detection Sequencer

This block is the digital control for far-end receiver detection in a two-lane serial-link redriver. An analog front end sends a probe pulse down each lane and feeds a one-bit comparator result back to the block. The block decides when to probe and how many times. It tracks which lanes have found a receiver. It also decides when the lane data paths and electrical-idle detectors may turn on.

Detection starts when the enable comes up and again on every edge of the trigger pin. All lanes are probed at the same time, once per retry period. The retries have no limit as long as no lane has found a receiver. When one lane succeeds, every lane that is still searching gets a small fixed number of extra attempts. The whole block stays in low-power standby, with all lanes squelched, until each lane has either found its receiver or used up its extra attempts. Pulse width, retry period, bounded attempt count and synchronizer depth are parameters.

Top module: `rxdet_seq`

## Requirements
- R1: While the synchronized enable is low, the block makes no probe pulses, every lane is squelched with its data path and idle detector off, and standby is high, whatever the trigger pin does.
- R2: A rise of the synchronized enable starts detection on all lanes without any trigger edge. This includes leaving reset with the enable already high.
- R3: While enabled, a rising or a falling edge of the trigger pin restarts detection on all lanes. A steady trigger level, high or low, starts no probe pulses.
- R4: While any lane is still pending, standby stays high and no lane has its data path enabled.
- R5: As long as no lane has detected a receiver, every lane keeps probing without limit.
- R6: In the sample where some lane first detects a receiver, each lane that did not detect gets at most TRIES further attempts (default 3). A lane that fails all of them stops probing. It stays squelched until the next restart.
- R7: Once every lane is resolved, standby falls. Each lane that detected a receiver then has its data path and idle detector enabled and its squelch low. Each lane that gave up keeps its squelch high and both enables low.
- R8: Each probe pulse lasts PULSE_CYC clock cycles (default 5). Pulses on a lane start PERIOD_CYC cycles apart (default 10).
- R9: A lane uses its comparator input only in the last cycle of its probe pulse. A high comparator input in any other cycle, or between pulses, has no effect.
- R10: All lanes are probed at the same time, and each lane is judged only on its own comparator input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Global enable pin (asynchronous) |
| trig_i | input | 1 | Detection trigger pin (asynchronous); either edge restarts detection |
| det_i | input | LANES | Per-lane comparator result, valid in the last cycle of a probe pulse |
| probe_o | output | LANES | Per-lane probe-pulse strobe |
| squelch_o | output | LANES | Per-lane output squelch, high means muted |
| data_en_o | output | LANES | Per-lane data-path enable |
| idle_en_o | output | LANES | Per-lane electrical-idle detector enable |
| standby_o | output | 1 | Low-power standby / shutdown flag |

## Verification
The hardest case to reach is a lane at the exact edge of its bounded window. Here the receiver appears on the last allowed attempt, or one attempt too late, after the other lane has already succeeded. The bench reaches it by counting the probe pulses on each lane as they happen. It drives the comparator high from a chosen attempt number onward, so the attempt where each lane detects is set directly. In every cycle of a pulse except the last, and between pulses, the comparator is driven with random noise. This tests the last-cycle sampling rule on every attempt.

// File: rtl/rxdet_pkg.sv
package rxdet_pkg;
   typedef enum logic [2:0] {
      LN_OFF     = 3'd0,
      LN_SEARCH  = 3'd1,
      LN_BOUNDED = 3'd2,
      LN_FOUND   = 3'd3,
      LN_GAVEUP  = 3'd4
   } lane_st_e;
endpackage

// File: rtl/rxdet_sync.sv
module rxdet_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rxdet_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rxdet_timer.sv
module rxdet_timer #(
   parameter int PULSE_CYC  = 5,
   parameter int PERIOD_CYC = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic in_pulse,
   output logic sample
);
   localparam int CW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
   localparam logic [CW-1:0] LAST_PER = CW'(PERIOD_CYC - 1);
   localparam logic [CW-1:0] LAST_PUL = CW'(PULSE_CYC - 1);
   localparam logic [CW-1:0] PUL      = CW'(PULSE_CYC);

   if (PULSE_CYC < 1) begin : g_bad_pulse
      $error("rxdet_timer: PULSE_CYC must be at least 1");
   end
   if (PERIOD_CYC <= PULSE_CYC) begin : g_bad_period
      $error("rxdet_timer: PERIOD_CYC must exceed PULSE_CYC");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (clear)           cnt <= '0;
      else if (cnt == LAST_PER) cnt <= '0;
      else                      cnt <= cnt + 1'b1;
   end

   assign in_pulse = (cnt < PUL);
   assign sample   = (cnt == LAST_PUL);
endmodule

// File: rtl/rxdet_lane.sv
module rxdet_lane
   import rxdet_pkg::*;
#(
   parameter int TRIES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_s,
   input  logic restart,
   input  logic in_pulse,
   input  logic sample,
   input  logic det,
   input  logic peer_hit,
   output logic probing_o,
   output logic hit_o,
   output logic found_o,
   output logic resolved_o
);
   localparam int TW = $clog2(TRIES + 1);
   localparam logic [TW-1:0] TRIES_W = TW'(TRIES);

   if (TRIES < 1) begin : g_bad_tries
      $error("rxdet_lane: TRIES must be at least 1");
   end

   lane_st_e      state;
   logic [TW-1:0] left;
   logic          active;

   assign active     = (state == LN_SEARCH) || (state == LN_BOUNDED);
   assign probing_o  = active & in_pulse;
   assign hit_o      = active & sample & det;
   assign found_o    = (state == LN_FOUND);
   assign resolved_o = (state == LN_FOUND) || (state == LN_GAVEUP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= LN_OFF;
         left  <= '0;
      end else if (!en_s) begin
         state <= LN_OFF;
         left  <= '0;
      end else if (restart) begin
         state <= LN_SEARCH;
         left  <= '0;
      end else if (active && sample) begin
         if (det) begin
            state <= LN_FOUND;
         end else if (state == LN_SEARCH) begin
            if (peer_hit) begin
               state <= LN_BOUNDED;
               left  <= TRIES_W;
            end
         end else if (left == TW'(1)) begin
            state <= LN_GAVEUP;
            left  <= '0;
         end else begin
            left <= left - 1'b1;
         end
      end
   end

   p_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |=> state == LN_OFF);

   p_tries_r6: assert property (@(posedge clk) disable iff (!rst_n)
      state == LN_BOUNDED |-> (left >= TW'(1)) && (left <= TRIES_W));

   p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      state == LN_FOUND && en_s && !restart |=> state == LN_FOUND);

   p_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(en_s) && !$past(restart) && state != $past(state) |-> $past(sample));

   p_pulse_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(probing_o) && $past(en_s) && !$past(restart) |-> $past(sample));
endmodule

// File: rtl/rxdet_seq.sv
module rxdet_seq #(
   parameter int LANES       = 2,
   parameter int PULSE_CYC   = 5,
   parameter int PERIOD_CYC  = 10,
   parameter int TRIES       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             trig_i,
   input  logic [LANES-1:0] det_i,
   output logic [LANES-1:0] probe_o,
   output logic [LANES-1:0] squelch_o,
   output logic [LANES-1:0] data_en_o,
   output logic [LANES-1:0] idle_en_o,
   output logic             standby_o
);
   if (LANES < 1) begin : g_bad_lanes
      $error("rxdet_seq: LANES must be at least 1");
   end

   logic en_s, en_q, trig_s, trig_q, restart;
   logic in_pulse, sample;
   logic [LANES-1:0] hit, found, resolved, peer;

   rxdet_sync #(.STAGES(SYNC_STAGES)) u_sync_en (
      .clk(clk), .rst_n(rst_n), .d(en_i), .q(en_s));

   rxdet_sync #(.STAGES(SYNC_STAGES)) u_sync_trig (
      .clk(clk), .rst_n(rst_n), .d(trig_i), .q(trig_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         trig_q <= 1'b0;
      end else begin
         en_q   <= en_s;
         trig_q <= trig_s;
      end
   end

   assign restart = en_s & (~en_q | (trig_s ^ trig_q));

   rxdet_timer #(.PULSE_CYC(PULSE_CYC), .PERIOD_CYC(PERIOD_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .clear(restart),
      .in_pulse(in_pulse), .sample(sample));

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign peer[i] = |(hit & ~(LANES'(1) << i));

      rxdet_lane #(.TRIES(TRIES)) u_lane (
         .clk(clk), .rst_n(rst_n), .en_s(en_s), .restart(restart),
         .in_pulse(in_pulse), .sample(sample), .det(det_i[i]),
         .peer_hit(peer[i]), .probing_o(probe_o[i]), .hit_o(hit[i]),
         .found_o(found[i]), .resolved_o(resolved[i]));
   end

   assign standby_o = ~en_s | ~(&resolved);
   assign data_en_o = found & {LANES{~standby_o}};
   assign idle_en_o = data_en_o;
   assign squelch_o = ~data_en_o;

   p_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(standby_o) |-> en_s && !restart);

   p_shut_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en_s) && !en_s |-> probe_o == '0 && data_en_o == '0);
endmodule

// File: tb/rxdet_seq_tb_top.sv
module rxdet_seq_tb_top;
   localparam int LANES  = 2;
   localparam int PULSE  = 5;
   localparam int PERIOD = 10;
   localparam int TRIES  = 3;
   localparam int WDOG   = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic trig = 1'b0;
   logic [LANES-1:0] det = '0;
   logic [LANES-1:0] probe, squelch, data_en, idle_en;
   logic standby;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   int a_at [LANES];
   int pcnt [LANES];
   int pcyc [LANES];
   int wid  [LANES];
   int per  [LANES];
   int lrise[LANES];
   logic [LANES-1:0] pp = '0;
   int viol = 0;
   int clr_gen = 0;
   int clr_seen = 0;

   always #10 clk = ~clk;

   rxdet_seq #(.LANES(LANES), .PULSE_CYC(PULSE), .PERIOD_CYC(PERIOD),
               .TRIES(TRIES), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .en_i(en), .trig_i(trig), .det_i(det),
      .probe_o(probe), .squelch_o(squelch), .data_en_o(data_en),
      .idle_en_o(idle_en), .standby_o(standby));

   initial begin
      for (int i = 0; i < LANES; i++) begin
         a_at[i] = 0; pcnt[i] = 0; pcyc[i] = 0;
         wid[i] = 0; per[i] = 0; lrise[i] = 0;
      end
   end

   // monitor and comparator model, away from the active edge
   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (clr_seen != clr_gen) begin
         clr_seen = clr_gen;
         for (int i = 0; i < LANES; i++) begin
            pcnt[i] = 0; pcyc[i] = 0; viol = 0;
         end
      end
      if (standby && (|data_en)) viol = viol + 1;
      for (int i = 0; i < LANES; i++) begin
         if (probe[i]) begin
            if (!pp[i]) begin
               pcnt[i] = pcnt[i] + 1;
               per[i] = cyc - lrise[i];
               lrise[i] = cyc;
               pcyc[i] = 1;
            end else begin
               pcyc[i] = pcyc[i] + 1;
            end
            if (a_at[i] != 0 && pcnt[i] >= a_at[i]) det[i] = 1'b1;
            else if (pcyc[i] < PULSE) det[i] = 1'($urandom % 2);
            else det[i] = 1'b0;
         end else begin
            if (pp[i]) wid[i] = pcyc[i];
            det[i] = 1'($urandom % 2);
         end
         pp[i] = probe[i];
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int first_hit(input int x0, input int x1);
      if (x0 == 0) return x1;
      if (x1 == 0) return x0;
      return (x0 < x1) ? x0 : x1;
   endfunction

   function automatic int exp_cnt(input int ai, input int m);
      if (ai != 0 && ai <= m + TRIES) return ai;
      return m + TRIES;
   endfunction

   function automatic bit exp_found(input int ai, input int m);
      return (ai != 0 && ai <= m + TRIES);
   endfunction

   task automatic wait_level(input logic v, input int lim, output bit ok);
      ok = 1'b0;
      for (int k = 0; k < lim; k++) begin
         @(negedge clk);
         if (standby == v) begin ok = 1'b1; break; end
      end
   endtask

   task automatic clear_stats();
      clr_gen = clr_gen + 1;
      @(negedge clk);
   endtask

   // one detection run; kick: 0 = already started, 1 = trigger edge
   task automatic run_case(input int x0, input int x1, input bit kick,
                           input string tag);
      int m; bit ok;
      a_at[0] = x0; a_at[1] = x1;
      if (kick) begin
         clear_stats();
         trig = ~trig;
         wait_level(1'b1, 20, ok);
         chk(ok, "R3", {tag, " trigger edge enters standby"}, int'(standby), 1);
      end
      wait_level(1'b0, 3000, ok);
      chk(ok, "R4", {tag, " standby released"}, int'(standby), 0);
      repeat (3 * PERIOD) @(negedge clk);
      m = first_hit(x0, x1);
      for (int i = 0; i < LANES; i++) begin
         chk(pcnt[i] == exp_cnt(a_at[i], m), "R6",
             $sformatf("%s lane%0d attempts", tag, i), pcnt[i], exp_cnt(a_at[i], m));
         chk(data_en[i] == exp_found(a_at[i], m) && idle_en[i] == data_en[i]
             && squelch[i] == !data_en[i], "R7",
             $sformatf("%s lane%0d enables", tag, i),
             int'({squelch[i], idle_en[i], data_en[i]}),
             exp_found(a_at[i], m) ? 3 : 4);
      end
      chk(viol == 0, "R4", {tag, " data enabled during standby"}, viol, 0);
      chk(probe == '0, "R6", {tag, " no probes after resolution"}, int'(probe), 0);
   endtask

   initial begin
      bit ok;
      int r0, r1, c0, c1;
      void'($urandom(32'h5eed_0042));

      // reset state with enable low
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(standby == 1'b1 && probe == '0 && data_en == '0 && squelch == '1
          && idle_en == '0, "R1", "reset outputs",
          int'({standby, squelch, data_en}), 'b11100);
      for (int k = 0; k < 6; k++) begin
         trig = ~trig;
         repeat (7) @(negedge clk);
      end
      chk(pcnt[0] == 0 && pcnt[1] == 0, "R1", "trigger ignored while disabled",
          pcnt[0] + pcnt[1], 0);
      chk(standby == 1'b1 && squelch == '1, "R1", "shutdown held",
          int'({standby, squelch}), 7);

      // reset with enable high: auto start
      rst_n = 1'b0;
      en = 1'b1;
      a_at[0] = 2; a_at[1] = 4;
      clear_stats();
      @(negedge clk);
      rst_n = 1'b1;
      wait_level(1'b1, 5, ok);
      run_case(2, 4, 1'b0, "R2 auto-start");

      // steady trigger level after resolution
      c0 = pcnt[0]; c1 = pcnt[1];
      repeat (60) @(negedge clk);
      chk(pcnt[0] == c0 && pcnt[1] == c1, "R3", "steady trigger level",
          pcnt[0] + pcnt[1], c0 + c1);

      // directed boundaries
      run_case(1, 0, 1'b1, "R6 give-up");
      run_case(3, 6, 1'b1, "R6 last bounded try");
      run_case(3, 7, 1'b1, "R6 one too late");
      run_case(0, 2, 1'b1, "R10 lane1 first");
      run_case(4, 4, 1'b1, "R10 both same");
      run_case(1, 1, 1'b1, "R9 first attempt");

      // unbounded search, then timing
      a_at[0] = 0; a_at[1] = 0;
      clear_stats();
      trig = ~trig;
      repeat (25 * PERIOD) @(negedge clk);
      chk(pcnt[0] >= 20 && pcnt[1] >= 20, "R5", "unbounded retries",
          pcnt[0] < pcnt[1] ? pcnt[0] : pcnt[1], 20);
      chk(standby == 1'b1 && data_en == '0, "R4", "standby while searching",
          int'(standby), 1);
      chk(wid[0] == PULSE && wid[1] == PULSE, "R8", "pulse width", wid[0], PULSE);
      chk(per[0] == PERIOD && per[1] == PERIOD, "R8", "retry period", per[0], PERIOD);
      chk(lrise[0] == lrise[1], "R10", "lanes probed together", lrise[0], lrise[1]);

      // disable mid-search
      en = 1'b0;
      repeat (5) @(negedge clk);
      clear_stats();
      repeat (40) @(negedge clk);
      chk(pcnt[0] == 0 && pcnt[1] == 0 && standby && squelch == '1, "R1",
          "disable stops search", pcnt[0] + pcnt[1], 0);

      // enable rise restarts without trigger edge
      a_at[0] = 5; a_at[1] = 0;
      en = 1'b1;
      run_case(5, 0, 1'b0, "R2 enable rise");

      // random mix
      for (int n = 0; n < 24; n++) begin
         r0 = $urandom % 9;
         r1 = $urandom % 9;
         if (r0 == 0 && r1 == 0) r1 = 1 + ($urandom % 8);
         run_case(r0, r1, 1'b1, $sformatf("R10 random %0d", n));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   always @(negedge clk) begin
      if (cyc > WDOG) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule